// File: doc/BRIEF.md
# Parity Bus Transceiver with Error Latch

This block joins two 8-bit data buses, called A and B, where the B side also carries a ninth line for parity. Two active-low enables select what the block does. It can move data from A to B and generate an odd-parity bit. It can move data from B to A and check the received parity. It can drive neither bus. When both enables are active, it moves data from A to B and deliberately drives the wrong parity bit, so that a receiver downstream can test its own error path. Data passes through uninverted in every direction. Each tri-state line is modelled as three separate signals: an input vector, an output vector and a drive-enable.

The parity check result passes through an error latch. While the latch enable is high, the latch is transparent. While the latch enable is low, the latch holds the result captured at the last clock edge on which it was high. An active-low clear empties the latch. The error output behaves like an open-collector line: the block only ever pulls the line low, and an active pull means an error.

Top module: `parity_xcvr`

## Requirements
- R1: With oe_a_ni=1 and oe_b_ni=0, b_o equals a_i, b_oe_o=1, par_oe_o=1 and a_oe_o=0.
- R2: In the A-to-B mode of R1, par_o makes the 9 bits {a_i, par_o} contain an odd number of ones.
- R3: With oe_a_ni=0 and oe_b_ni=0, data moves from A to B as in R1, but par_o is inverted, so the 9 bits {a_i, par_o} contain an even number of ones.
- R4: With oe_a_ni=0 and oe_b_ni=1, a_o equals b_i, a_oe_o=1, b_oe_o=0 and par_oe_o=0.
- R5: With oe_a_ni=1 and oe_b_ni=1, a_oe_o, b_oe_o and par_oe_o are all 0.
- R6: In the B-to-A mode, the check result is error when {b_i, par_i} holds an even number of ones. An error is shown as err_drive_low_o=1.
- R7: In any mode other than B-to-A, the check result is no-error, whatever b_i and par_i hold.
- R8: With le_i=1 and clr_ni=1, err_drive_low_o follows the current check result in the same cycle.
- R9: With le_i=0 and clr_ni=1, err_drive_low_o holds the check result sampled at the last rising clk_i edge at which le_i was 1. It ignores any later input changes.
- R10: clr_ni=0 forces err_drive_low_o to 0 at once, even when le_i=1. A rising clk_i edge taken with clr_ni=0 leaves the held result at no-error.
- R11: After reset the held result is no-error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the error latch |
| rst_ni | input | 1 | Asynchronous reset, active low |
| oe_a_ni | input | 1 | A-side enable, active low |
| oe_b_ni | input | 1 | B-side enable, active low |
| le_i | input | 1 | Error latch enable: 1 transparent, 0 hold |
| clr_ni | input | 1 | Error latch clear, active low |
| a_i | input | DATA_W | Value seen on the A bus |
| a_o | output | DATA_W | Value driven onto the A bus |
| a_oe_o | output | 1 | A bus drive enable |
| b_i | input | DATA_W | Value seen on the B bus |
| b_o | output | DATA_W | Value driven onto the B bus |
| b_oe_o | output | 1 | B bus drive enable |
| par_i | input | 1 | Parity line as received |
| par_o | output | 1 | Parity line as driven |
| par_oe_o | output | 1 | Parity line drive enable |
| err_drive_low_o | output | 1 | 1 pulls the error line low (error) |

## Verification
Errors in the enable decode or the parity tree show up on the bus outputs in the same cycle. For that reason the bench sweeps every data value in both directions, plus the inverted-parity mode. A wrong held error bit appears only once le_i is low. The bench therefore captures a result, changes the B inputs so that the live check would give the opposite answer, and watches err_drive_low_o over several edges. It uses the same approach to show that a clear, and a clear taken at a clock edge, both remove a captured error.

// File: rtl/ptx_pkg.sv
package ptx_pkg;
  typedef enum logic [1:0] {
    MODE_ISO    = 2'd0,
    MODE_A2B    = 2'd1,
    MODE_B2A    = 2'd2,
    MODE_A2B_FX = 2'd3
  } ptx_mode_e;
endpackage

// File: rtl/ptx_dir_decode.sv
module ptx_dir_decode
  import ptx_pkg::*;
(
  input  logic      oe_a_ni,
  input  logic      oe_b_ni,
  output ptx_mode_e mode_o
);
  always_comb begin
    unique case ({oe_a_ni, oe_b_ni})
      2'b10:   mode_o = MODE_A2B;
      2'b01:   mode_o = MODE_B2A;
      2'b00:   mode_o = MODE_A2B_FX;
      default: mode_o = MODE_ISO;
    endcase
  end
endmodule

// File: rtl/ptx_xor_tree.sv
module ptx_xor_tree #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] d_i,
  output logic         x_o
);
  logic [W-1:0] acc;
  assign acc[0] = d_i[0];
  for (genvar k = 1; k < W; k++) begin : g_chain
    assign acc[k] = acc[k-1] ^ d_i[k];
  end
  assign x_o = acc[W-1];
endmodule

// File: rtl/ptx_err_latch.sv
module ptx_err_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic le_i,
  input  logic clr_ni,
  input  logic chk_err_i,
  output logic err_o
);
  logic err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      err_q <= 1'b0;
    else if (!clr_ni) err_q <= 1'b0;
    else if (le_i)    err_q <= chk_err_i;
  end

  // clear wins over transparency
  assign err_o = !clr_ni ? 1'b0 : (le_i ? chk_err_i : err_q);
endmodule

// File: rtl/parity_xcvr.sv
module parity_xcvr
  import ptx_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              oe_a_ni,
  input  logic              oe_b_ni,
  input  logic              le_i,
  input  logic              clr_ni,
  input  logic [DATA_W-1:0] a_i,
  output logic [DATA_W-1:0] a_o,
  output logic              a_oe_o,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] b_o,
  output logic              b_oe_o,
  input  logic              par_i,
  output logic              par_o,
  output logic              par_oe_o,
  output logic              err_drive_low_o
);
  localparam int unsigned CHK_W = DATA_W + 1;

  ptx_mode_e mode;
  logic      a_xor, chk_xor, chk_err;

  ptx_dir_decode u_dec (
    .oe_a_ni (oe_a_ni),
    .oe_b_ni (oe_b_ni),
    .mode_o  (mode)
  );

  ptx_xor_tree #(.W(DATA_W)) u_gen (
    .d_i (a_i),
    .x_o (a_xor)
  );

  ptx_xor_tree #(.W(CHK_W)) u_chk (
    .d_i ({par_i, b_i}),
    .x_o (chk_xor)
  );

  always_comb begin
    a_oe_o   = 1'b0;
    b_oe_o   = 1'b0;
    par_oe_o = 1'b0;
    par_o    = ~a_xor;
    chk_err  = 1'b0;
    unique case (mode)
      MODE_A2B: begin
        b_oe_o   = 1'b1;
        par_oe_o = 1'b1;
      end
      MODE_A2B_FX: begin
        b_oe_o   = 1'b1;
        par_oe_o = 1'b1;
        par_o    = a_xor;  // forced even parity
      end
      MODE_B2A: begin
        a_oe_o  = 1'b1;
        chk_err = ~chk_xor;
      end
      default: ;
    endcase
  end

  assign a_o = b_i;
  assign b_o = a_i;

  ptx_err_latch u_lat (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .le_i      (le_i),
    .clr_ni    (clr_ni),
    .chk_err_i (chk_err),
    .err_o     (err_drive_low_o)
  );
endmodule

// File: rtl/ptx_checker.sv
module ptx_checker #(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              oe_a_ni,
  input logic              oe_b_ni,
  input logic              le_i,
  input logic              clr_ni,
  input logic [DATA_W-1:0] a_i,
  input logic [DATA_W-1:0] a_o,
  input logic              a_oe_o,
  input logic [DATA_W-1:0] b_i,
  input logic [DATA_W-1:0] b_o,
  input logic              b_oe_o,
  input logic              par_i,
  input logic              par_o,
  input logic              par_oe_o,
  input logic              err_drive_low_o
);
  assert_a2b_data_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!oe_b_ni) |-> (b_oe_o && par_oe_o && !a_oe_o && b_o == a_i));

  assert_odd_par_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oe_a_ni && !oe_b_ni) |-> ($countones({a_i, par_o}) % 2 == 1));

  assert_forced_par_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!oe_a_ni && !oe_b_ni) |-> ($countones({a_i, par_o}) % 2 == 0));

  assert_b2a_data_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!oe_a_ni && oe_b_ni) |-> (a_oe_o && !b_oe_o && !par_oe_o && a_o == b_i));

  assert_isolate_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oe_a_ni && oe_b_ni) |-> !(a_oe_o || b_oe_o || par_oe_o));

  assert_no_recv_err_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (le_i && !(!oe_a_ni && oe_b_ni)) |-> !err_drive_low_o);

  assert_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!le_i && $past(!le_i) && clr_ni && $past(clr_ni)) |-> $stable(err_drive_low_o));

  assert_clear_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_ni) |-> !err_drive_low_o);
endmodule

bind parity_xcvr ptx_checker #(.DATA_W(DATA_W)) u_ptx_checker (
  .clk_i(clk_i), .rst_ni(rst_ni), .oe_a_ni(oe_a_ni), .oe_b_ni(oe_b_ni),
  .le_i(le_i), .clr_ni(clr_ni), .a_i(a_i), .a_o(a_o), .a_oe_o(a_oe_o),
  .b_i(b_i), .b_o(b_o), .b_oe_o(b_oe_o), .par_i(par_i), .par_o(par_o),
  .par_oe_o(par_oe_o), .err_drive_low_o(err_drive_low_o)
);

// File: tb/tb_parity_xcvr.sv
`timescale 1ns/1ps
module tb_parity_xcvr;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic oe_a_n = 1'b1, oe_b_n = 1'b1, le = 1'b0, clr_n = 1'b1, par_in = 1'b0;
  logic [W-1:0] a_in = '0, b_in = '0;
  logic [W-1:0] a_out, b_out;
  logic a_oe, b_oe, par_out, par_oe, err;
  int tests = 0, fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  parity_xcvr #(.DATA_W(W)) dut (
    .clk_i(clk), .rst_ni(rst_n), .oe_a_ni(oe_a_n), .oe_b_ni(oe_b_n),
    .le_i(le), .clr_ni(clr_n), .a_i(a_in), .a_o(a_out), .a_oe_o(a_oe),
    .b_i(b_in), .b_o(b_out), .b_oe_o(b_oe), .par_i(par_in), .par_o(par_out),
    .par_oe_o(par_oe), .err_drive_low_o(err)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic set_mode(input logic na, input logic nb);
    oe_a_n = na; oe_b_n = nb;
  endtask

  task automatic t_reset();
    set_mode(1'b0, 1'b1); le = 1'b0; b_in = '0; par_in = 1'b0;
    #1;
    check("R11 held clear in reset", {31'd0, err}, 32'd0);
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    #1;
    check("R11 held clear after reset", {31'd0, err}, 32'd0);
  endtask

  task automatic t_a2b();
    le = 1'b1; set_mode(1'b1, 1'b0);
    for (int v = 0; v < 256; v++) begin
      a_in = W'(v); #1;
      check("R1 b data", {24'd0, b_out}, v);
      check("R1 enables", {29'd0, a_oe, b_oe, par_oe}, 32'b011);
      check("R2 odd parity", {31'd0, par_out}, {31'd0, ~(^a_in)});
      check("R7 no err when sending", {31'd0, err}, 32'd0);
    end
  endtask

  task automatic t_forced();
    le = 1'b1; set_mode(1'b0, 1'b0);
    for (int v = 0; v < 256; v++) begin
      a_in = W'(v); b_in = '0; par_in = 1'b0; #1;
      check("R3 b data", {24'd0, b_out}, v);
      check("R3 enables", {29'd0, a_oe, b_oe, par_oe}, 32'b011);
      check("R3 even parity", {31'd0, par_out}, {31'd0, ^a_in});
      check("R7 no err forced", {31'd0, err}, 32'd0);
    end
  endtask

  task automatic t_b2a();
    le = 1'b1; clr_n = 1'b1; set_mode(1'b0, 1'b1);
    for (int v = 0; v < 256; v++) begin
      b_in = W'(v); par_in = ~(^b_in); #1;
      check("R4 a data", {24'd0, a_out}, v);
      check("R4 enables", {29'd0, a_oe, b_oe, par_oe}, 32'b100);
      check("R6 good parity", {31'd0, err}, 32'd0);
    end
  endtask

  task automatic t_corrupt();
    le = 1'b1; set_mode(1'b0, 1'b1);
    for (int v = 0; v < 256; v += 17) begin
      for (int k = 0; k <= W; k++) begin
        logic [W:0] word;
        word = {~(^W'(v)), W'(v)};
        word[k] = ~word[k];
        b_in = word[W-1:0]; par_in = word[W]; #1;
        check("R6 single-bit flip", {31'd0, err}, 32'd1);
        check("R8 transparent", {31'd0, err}, {31'd0, ~(^word)});
      end
    end
  endtask

  task automatic t_isolate();
    set_mode(1'b1, 1'b1); le = 1'b1; b_in = 8'h00; par_in = 1'b0; a_in = 8'h5a; #1;
    check("R5 all released", {29'd0, a_oe, b_oe, par_oe}, 32'd0);
    check("R7 no err isolated", {31'd0, err}, 32'd0);
  endtask

  task automatic t_hold();
    @(negedge clk); set_mode(1'b0, 1'b1); clr_n = 1'b1; le = 1'b1;
    b_in = 8'h00; par_in = 1'b0;
    @(posedge clk);
    @(negedge clk); le = 1'b0; par_in = 1'b1; #1;
    check("R9 holds error", {31'd0, err}, 32'd1);
    repeat (3) @(posedge clk);
    @(negedge clk); b_in = 8'h03;
    check("R9 still error", {31'd0, err}, 32'd1);
    le = 1'b1; b_in = 8'h00; #1;
    check("R8 live good", {31'd0, err}, 32'd0);
    @(posedge clk);
    @(negedge clk); le = 1'b0; par_in = 1'b0; #1;
    check("R9 holds no-error", {31'd0, err}, 32'd0);
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R9 no-error stable", {31'd0, err}, 32'd0);
  endtask

  task automatic t_clear();
    @(negedge clk); set_mode(1'b0, 1'b1); le = 1'b1; clr_n = 1'b1;
    b_in = 8'h01; par_in = 1'b1; #1;
    check("R8 live error", {31'd0, err}, 32'd1);
    @(posedge clk);
    @(negedge clk); le = 1'b0; #1;
    check("R9 captured", {31'd0, err}, 32'd1);
    clr_n = 1'b0; #1;
    check("R10 clear at once", {31'd0, err}, 32'd0);
    @(posedge clk);
    @(negedge clk); clr_n = 1'b1; #1;
    check("R10 held cleared", {31'd0, err}, 32'd0);
    le = 1'b1; clr_n = 1'b0; #1;
    check("R10 overrides le", {31'd0, err}, 32'd0);
    @(posedge clk);
    @(negedge clk); le = 1'b0; clr_n = 1'b1; #1;
    check("R10 clear beats capture", {31'd0, err}, 32'd0);
  endtask

  initial begin
    t_reset();
    t_a2b();
    t_forced();
    t_b2a();
    t_corrupt();
    t_isolate();
    t_hold();
    t_clear();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule